// File: doc/BRIEF.md
# Asynchronous Serial Port with Coded Rate Select

This block is a full-duplex asynchronous serial port that a processor controls through a small register bus. The processor loads characters into a one-deep transmit holding register and takes received characters from a one-deep receive register. It reads line and error state from a status byte and sets the framing and line controls through a mode byte and a command byte. The bit rate is chosen by writing a 4-bit code on a separate port. The code indexes a fixed, deliberately irregular table of standard rates. Each rate is derived from the system clock by an integer divider that produces a 16x sampling tick.

The serial character is framed as follows: one low start bit, then 7 or 8 data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Received characters raise an interrupt request that stays up until the processor reads the receive register. Parity, framing and overrun errors remain set until the processor clears them with a command bit.

Back-pressure on the data paths is carried by the status bits; the bus itself never stalls. A transmit write is taken only while the transmit-ready status bit is 1, and a write made while it is 0 is dropped. A received character waits in the receive register until it is read. A character that completes while the previous one is unread is discarded and flagged as an overrun.

Top module: `sercom_core`

## Requirements
- R1: The rate code selects the bit rate as follows: 0000=110, 0001=150, 0010=300, 0011=600, 0100=1200, 0101=2400, 0110=4800, 0111=9600, 1000=1200, 1001=75, 1010=19200, 1011=38400, 1100=200, and 1101/1110/1111=9600. One bit lasts 16*floor(CLK_HZ/(16*rate)) clock cycles, with a minimum of 16. The code is 0111 after reset.
- R2: The transmitter sends a character as follows: a low start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits, high. Mode byte bit 2 = 1 selects 8 data bits, otherwise 7. Bit 4 = 1 enables parity. Bit 5 = 1 selects even parity, otherwise odd. Bit 7 = 1 selects two stop bits.
- R3: The receiver uses the same mode byte. It passes rxd through two flops and confirms the start bit 8 ticks after it is seen. A low pulse shorter than half a bit is rejected. Each later bit is sampled 16 ticks after the previous one. A 7-bit character is read with bit 7 = 0. After a stop bit is sampled low, the receiver waits for the line to go high before it looks for a new start bit.
- R4: The status byte holds, from bit 7 down: DSR input, 0, framing error, overrun, parity error, transmitter empty, receive ready, transmit ready.
- R5: Transmit ready is 1 while the holding register is free. A write to the holding register while it is full is ignored. Transmitter empty is 1 only when both the holding register and the shifter are idle. A character leaves the holding register only while command bit 0 (transmit enable) is 1.
- R6: A read of the receive register clears receive ready. irq is 1 exactly while receive ready is 1.
- R7: When a character completes while receive ready is still 1, the overrun flag is set. The new character is discarded and the unread one is kept.
- R8: A parity error is flagged when the received parity bit disagrees with the mode. A framing error is flagged when the first stop bit is sampled low. The character is still delivered in both cases. The overrun, framing and parity flags stay set until a command write with bit 4 = 1 clears them, and nothing else clears them.
- R9: Command bit 3 = 1 holds txd low from the cycle after the write until a command write clears the bit.
- R10: Command bit 5 drives rts_out and command bit 1 drives dtr_out.
- R11: Command bit 2 enables the receiver. While it is 0, incoming frames are ignored.
- R12: After reset, txd, rts_out, dtr_out and irq are at 1, 0, 0 and 0. The status byte reads 0x05 with DSR low. The mode and command bytes are 0.
- R13: On the register bus, address 0 reads the receive register and writes the transmit register. Address 1 reads status and writes mode. Address 2 writes command. A read of address 2 or 3 returns 0. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rate_wr | input | 1 | Load the rate code |
| rate_code | input | 4 | Rate code |
| rxd | input | 1 | Serial receive line, asynchronous |
| dsr_in | input | 1 | Data-set-ready level reported in status |
| txd | output | 1 | Serial transmit line |
| rts_out | output | 1 | Request-to-send level |
| dtr_out | output | 1 | Data-terminal-ready level |
| irq | output | 1 | Receive-ready interrupt request |

## Verification
The bench measures the low time of an all-zero character at several rate codes, including the duplicated 1200 code and the unlisted codes. A divider decoded wrongly would give a start-plus-data time outside the one-divider tolerance. Random characters in random modes are framed in both directions, so a swapped parity sense, a wrong length decode or a missing second stop bit produces a wrong bit at a mid-bit sample. Directed cases cover the following:
- a second character that lands on an unread one must leave the first in place;
- a short low glitch must not deliver a character;
- error flags must survive a data read and clear only on the command bit;
- a write made while the holding register is full must not replace the waiting byte.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_HOLD
  } ser_st_e;

  typedef struct packed {
    logic two_stop;
    logic even;
    logic par_en;
    logic eight;
  } frame_cfg_t;

  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned SLOWEST_RATE  = 75;

  function automatic int unsigned rate_of(input logic [3:0] code);
    case (code)
      4'b0000: return 110;
      4'b0001: return 150;
      4'b0010: return 300;
      4'b0011: return 600;
      4'b0100: return 1200;
      4'b0101: return 2400;
      4'b0110: return 4800;
      4'b0111: return 9600;
      4'b1000: return 1200;
      4'b1001: return 75;
      4'b1010: return 19200;
      4'b1011: return 38400;
      4'b1100: return 200;
      default: return 9600;
    endcase
  endfunction

  function automatic int unsigned div_of(input int unsigned clk_hz, input logic [3:0] code);
    int unsigned d;
    d = clk_hz / (TICKS_PER_BIT * rate_of(code));
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic eight, input logic even);
    logic p;
    p = ^(eight ? d : {1'b0, d[6:0]});
    return even ? p : ~p;
  endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
  parameter int unsigned CLK_HZ = 1_843_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       code_wr,
  input  logic [3:0] code_in,
  output logic       tick
);
  import sercom_pkg::*;

  localparam int unsigned MAX_DIV = CLK_HZ / (TICKS_PER_BIT * SLOWEST_RATE) + 1;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1) + 1;

  logic [3:0]       code_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_sel;

  always_comb div_sel = DIV_W'(div_of(CLK_HZ, code_q));

  assign tick = (cnt_q == div_sel - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 4'b0111;
      cnt_q  <= '0;
    end else if (code_wr) begin
      code_q <= code_in;
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       brk,
  input  frame_cfg_t cfg,
  input  logic       hold_wr,
  input  logic [7:0] hold_din,
  output logic       txd,
  output logic       hold_rdy,
  output logic       tx_empty
);
  ser_st_e    st_q;
  frame_cfg_t cur_q;
  logic [7:0] hold_q;
  logic       hold_full_q;
  logic [7:0] sh_q;
  logic       par_q;
  logic [3:0] sub_q;
  logic [2:0] bit_q;
  logic       line;
  logic       start_load;
  logic [2:0] last_bit;

  assign start_load = (st_q == ST_IDLE) && hold_full_q && tx_en;
  assign last_bit   = cur_q.eight ? 3'd7 : 3'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      par_q       <= 1'b0;
      sub_q       <= '0;
      bit_q       <= '0;
    end else begin
      if (hold_wr && !hold_full_q) begin
        hold_q      <= hold_din;
        hold_full_q <= 1'b1;
      end
      if (start_load) begin
        hold_full_q <= 1'b0;
        sh_q        <= hold_q;
        cur_q       <= cfg;
        par_q       <= par_of(hold_q, cfg.eight, cfg.even);
        st_q        <= ST_START;
        sub_q       <= '0;
      end else if (st_q != ST_IDLE && tick) begin
        if (sub_q != 4'd15) begin
          sub_q <= sub_q + 4'd1;
        end else begin
          sub_q <= '0;
          case (st_q)
            ST_START: begin
              st_q  <= ST_DATA;
              bit_q <= '0;
            end
            ST_DATA: begin
              sh_q <= {1'b0, sh_q[7:1]};
              if (bit_q == last_bit) st_q <= cur_q.par_en ? ST_PAR : ST_STOP;
              else                   bit_q <= bit_q + 3'd1;
            end
            ST_PAR:   st_q <= ST_STOP;
            ST_STOP:  st_q <= cur_q.two_stop ? ST_STOP2 : ST_IDLE;
            default:  st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign txd      = line & ~brk;
  assign hold_rdy = ~hold_full_q;
  assign tx_empty = ~hold_full_q && (st_q == ST_IDLE);
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  frame_cfg_t cfg,
  input  logic       rxd_async,
  input  logic       take,
  input  logic       clr_err,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       ovr_err,
  output logic       frm_err,
  output logic       par_err,
  output logic       fin
);
  logic       s1_q, s2_q;
  ser_st_e    st_q;
  frame_cfg_t cur_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic [2:0] bit_q;
  logic       pbit_q;
  logic [7:0] dat_w;
  logic       bad_par;
  logic [2:0] last_bit;

  assign last_bit = cur_q.eight ? 3'd7 : 3'd6;
  assign dat_w    = cur_q.eight ? sh_q : {1'b0, sh_q[7:1]};
  assign bad_par  = cur_q.par_en && (pbit_q != par_of(dat_w, 1'b1, cur_q.even));
  assign fin      = rx_en && tick && (st_q == ST_STOP) && (cnt_q == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_async;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
      pbit_q <= 1'b0;
    end else if (!rx_en) begin
      st_q <= ST_IDLE;
    end else if (st_q == ST_HOLD) begin
      if (s2_q) st_q <= ST_IDLE;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: if (!s2_q) begin
          st_q  <= ST_START;
          cnt_q <= '0;
          cur_q <= cfg;
        end
        ST_START: begin
          if (cnt_q == 4'd7) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= s2_q ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        default: begin
          if (cnt_q != 4'd15) begin
            cnt_q <= cnt_q + 4'd1;
          end else begin
            cnt_q <= '0;
            case (st_q)
              ST_DATA: begin
                sh_q <= {s2_q, sh_q[7:1]};
                if (bit_q == last_bit) st_q <= cur_q.par_en ? ST_PAR : ST_STOP;
                else                   bit_q <= bit_q + 3'd1;
              end
              ST_PAR: begin
                pbit_q <= s2_q;
                st_q   <= ST_STOP;
              end
              default: st_q <= s2_q ? ST_IDLE : ST_HOLD;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      ovr_err  <= 1'b0;
      frm_err  <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      if (fin && !rx_ready) begin
        rx_data  <= dat_w;
        rx_ready <= 1'b1;
      end else if (take) begin
        rx_ready <= 1'b0;
      end
      ovr_err <= (ovr_err & ~clr_err) | (fin & rx_ready);
      frm_err <= (frm_err & ~clr_err) | (fin & ~rx_ready & ~s2_q);
      par_err <= (par_err & ~clr_err) | (fin & ~rx_ready & bad_par);
    end
  end
endmodule

// File: rtl/sercom_core.sv
module sercom_core #(
  parameter int unsigned CLK_HZ = 1_843_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rate_wr,
  input  logic [3:0] rate_code,
  input  logic       rxd,
  input  logic       dsr_in,
  output logic       txd,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       irq
);
  import sercom_pkg::*;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;

  frame_cfg_t cfg_q;
  logic       c_rts_q, c_brk_q, c_rxen_q, c_dtr_q, c_txen_q;
  logic       tick;
  logic       hold_rdy, tx_empty;
  logic [7:0] rx_data;
  logic       rx_ready, ovr_err, frm_err, par_err, rx_fin;
  logic [7:0] stat_w;
  logic       wr_cmd, clr_err, take;

  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign clr_err = wr_cmd && bus_wdata[4];
  assign take    = bus_rd && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      c_rts_q  <= 1'b0;
      c_brk_q  <= 1'b0;
      c_rxen_q <= 1'b0;
      c_dtr_q  <= 1'b0;
      c_txen_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_STAT) begin
        cfg_q.two_stop <= bus_wdata[7];
        cfg_q.even     <= bus_wdata[5];
        cfg_q.par_en   <= bus_wdata[4];
        cfg_q.eight    <= bus_wdata[2];
      end
      if (wr_cmd) begin
        c_rts_q  <= bus_wdata[5];
        c_brk_q  <= bus_wdata[3];
        c_rxen_q <= bus_wdata[2];
        c_dtr_q  <= bus_wdata[1];
        c_txen_q <= bus_wdata[0];
      end
    end
  end

  sercom_baud #(.CLK_HZ(CLK_HZ)) baud_i (
    .clk(clk), .rst_n(rst_n), .code_wr(rate_wr), .code_in(rate_code), .tick(tick)
  );

  sercom_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(c_txen_q), .brk(c_brk_q),
    .cfg(cfg_q), .hold_wr(bus_wr && bus_addr == A_DATA), .hold_din(bus_wdata),
    .txd(txd), .hold_rdy(hold_rdy), .tx_empty(tx_empty)
  );

  sercom_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(c_rxen_q), .cfg(cfg_q),
    .rxd_async(rxd), .take(take), .clr_err(clr_err),
    .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err),
    .frm_err(frm_err), .par_err(par_err), .fin(rx_fin)
  );

  assign stat_w = {dsr_in, 1'b0, frm_err, ovr_err, par_err, tx_empty, rx_ready, hold_rdy};

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_data;
      A_STAT:  bus_rdata = stat_w;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign rts_out = c_rts_q;
  assign dtr_out = c_dtr_q;
  assign irq     = rx_ready;
endmodule

// File: rtl/sercom_chk.sv
module sercom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       txd,
  input logic [7:0] stat,
  input logic       rx_fin
);
  logic clr_w;
  assign clr_w = bus_wr && bus_addr == 2'd2 && bus_wdata[4];

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && bus_wdata[3]) |=> !txd); // R9
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && !rx_fin) |=> !stat[1]); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && stat[1]) |=> stat[4]); // R7
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !rx_fin) |=> (stat[5:3] == 3'b000)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5] && !clr_w) |=> stat[5]); // R8
  AST_HOLD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && stat[0]) |=> !stat[0]); // R5
endmodule

bind sercom_core sercom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .txd(txd), .stat(stat_w), .rx_fin(rx_fin)
);

// File: tb/sercom_core_tb_top.sv
module sercom_core_tb_top;
  localparam int CLK_HZ = 1_228_800;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rate_wr = 1'b0;
  logic [3:0] rate_code = '0;
  logic       rxd = 1'b1;
  logic       dsr_in = 1'b0;
  logic       txd, rts_out, dtr_out, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int bitc = 32;

  always #4 clk = ~clk;

  sercom_core #(.CLK_HZ(CLK_HZ)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int div_for(input logic [3:0] c);
    int r;
    case (c)
      4'd0: r = 110;   4'd1: r = 150;   4'd2: r = 300;   4'd3: r = 600;
      4'd4: r = 1200;  4'd5: r = 2400;  4'd6: r = 4800;  4'd7: r = 9600;
      4'd8: r = 1200;  4'd9: r = 75;    4'd10: r = 19200; 4'd11: r = 38400;
      4'd12: r = 200;  default: r = 9600;
    endcase
    return (CLK_HZ / (16 * r) == 0) ? 1 : CLK_HZ / (16 * r);
  endfunction

  function automatic logic bpar(input logic [7:0] d, input bit eight, input bit even);
    logic p;
    p = 1'b0;
    for (int i = 0; i < (eight ? 8 : 7); i++) p ^= d[i];
    return even ? p : ~p;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_rate(input logic [3:0] c);
    @(negedge clk); rate_wr = 1'b1; rate_code = c;
    @(negedge clk); rate_wr = 1'b0;
    bitc = 16 * div_for(c);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit eight, input bit pen, input bit even,
                             input bit two, input bit bad_par, input bit bad_stop);
    @(negedge clk); rxd = 1'b0; repeat (bitc) @(negedge clk);
    for (int i = 0; i < (eight ? 8 : 7); i++) begin
      rxd = d[i]; repeat (bitc) @(negedge clk);
    end
    if (pen) begin
      rxd = bpar(d, eight, even) ^ bad_par; repeat (bitc) @(negedge clk);
    end
    rxd = ~bad_stop; repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    if (two) repeat (bitc) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cap_tx(input string req, input logic [7:0] d, input bit eight, input bit pen,
                        input bit even, input bit two);
    logic [7:0] got;
    int t;
    got = '0; t = 0;
    while (txd !== 1'b0 && t < 20 * bitc) begin @(negedge clk); t++; end
    repeat (bitc / 2) @(negedge clk);
    chk({req, " start bit"}, txd, 0);
    for (int i = 0; i < (eight ? 8 : 7); i++) begin
      repeat (bitc) @(negedge clk); got[i] = txd;
    end
    chk({req, " data"}, got, eight ? d : {1'b0, d[6:0]});
    if (pen) begin
      repeat (bitc) @(negedge clk);
      chk({req, " parity"}, txd, bpar(d, eight, even));
    end
    repeat (bitc) @(negedge clk); chk({req, " stop1"}, txd, 1);
    if (two) begin repeat (bitc) @(negedge clk); chk({req, " stop2"}, txd, 1); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    logic [7:0] m;
    int lo;
    void'($urandom(32'h5EC0_0A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset values
    chk("R12 txd", txd, 1); chk("R12 rts", rts_out, 0);
    chk("R12 dtr", dtr_out, 0); chk("R12 irq", irq, 0);
    rd(2'd1, v); chk("R12 status", v, 8'h05);
    rd(2'd0, v); chk("R12 rxdata", v, 8'h00);
    // R13 unused addresses
    rd(2'd2, v); chk("R13 addr2", v, 0);
    rd(2'd3, v); chk("R13 addr3", v, 0);
    // R4 DSR
    dsr_in = 1'b1; rd(2'd1, v); chk("R4 dsr bit7", v, 8'h85); dsr_in = 1'b0;
    // R10 modem lines
    wr(2'd2, 8'h22); chk("R10 rts", rts_out, 1); chk("R10 dtr", dtr_out, 1);
    wr(2'd2, 8'h20); chk("R10 dtr only rts", {rts_out, dtr_out}, 2'b10);
    wr(2'd2, 8'h02); chk("R10 dtr only", {rts_out, dtr_out}, 2'b01);
    // R1 rate codes: low time of an all-zero 8N1 character
    wr(2'd1, 8'h04); wr(2'd2, 8'h01);
    foreach (m[i]) begin end
    for (int k = 0; k < 9; k++) begin
      logic [3:0] codes [9] = '{4'b1011, 4'b1010, 4'b0111, 4'b0110, 4'b0101,
                                4'b1101, 4'b1111, 4'b1000, 4'b0100};
      set_rate(codes[k]);
      wr(2'd0, 8'h00);
      lo = 0;
      while (txd !== 1'b0) @(negedge clk);
      while (txd === 1'b0 && lo < 200000) begin @(negedge clk); lo++; end
      n_chk++;
      if (lo < 144 * div_for(codes[k]) - div_for(codes[k]) || lo > 144 * div_for(codes[k]) + 1) begin
        n_bad++;
        $display("FAIL R1 code %b low time actual=%0d expected=%0d", codes[k], lo, 144 * div_for(codes[k]));
      end
      repeat (bitc + 4) @(negedge clk);
    end
    set_rate(4'b1011);
    // R2 random transmit frames
    for (int k = 0; k < 8; k++) begin
      m = 8'($urandom) & 8'hB4; d = 8'($urandom);
      wr(2'd1, m);
      wr(2'd0, d);
      cap_tx("R2 tx", d, m[2], m[4], m[5], m[7]);
      repeat (bitc) @(negedge clk);
      rd(2'd1, v); chk("R5 empty after frame", v & 8'h05, 8'h05);
    end
    // R5 transmit enable gating and full-holding write ignored
    wr(2'd1, 8'h04); wr(2'd2, 8'h04);
    wr(2'd0, 8'hA5);
    repeat (3 * bitc) @(negedge clk);
    chk("R5 txd idle while disabled", txd, 1);
    rd(2'd1, v); chk("R5 holding full", v & 8'h05, 8'h00);
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'h05);
    cap_tx("R5 kept byte", 8'hA5, 1, 0, 0, 0);
    repeat (4 * bitc) @(negedge clk);
    chk("R5 no second frame", txd, 1);
    rd(2'd1, v); chk("R5 idle status", v & 8'h05, 8'h05);
    // R9 break
    wr(2'd2, 8'h0D); @(negedge clk); chk("R9 break low", txd, 0);
    repeat (bitc) @(negedge clk); chk("R9 break held", txd, 0);
    wr(2'd2, 8'h05); @(negedge clk); chk("R9 break released", txd, 1);
    // R3 random receive frames, R6 irq and read clear
    for (int k = 0; k < 8; k++) begin
      m = 8'($urandom) & 8'hB4; d = 8'($urandom);
      wr(2'd1, m);
      drive_frame(d, m[2], m[4], m[5], m[7], 0, 0);
      chk("R6 irq up", irq, 1);
      rd(2'd1, v); chk("R3 status ready", v & 8'h3A, 8'h02);
      rd(2'd0, v); chk("R3 rx data", v, m[2] ? d : {1'b0, d[6:0]});
      chk("R6 irq down after read", irq, 0);
      rd(2'd1, v); chk("R6 ready cleared", v & 8'h02, 0);
    end
    // R3 glitch rejection
    wr(2'd1, 8'h04);
    @(negedge clk); rxd = 1'b0; repeat (bitc / 5) @(negedge clk); rxd = 1'b1;
    repeat (12 * bitc) @(negedge clk);
    rd(2'd1, v); chk("R3 glitch rejected", v & 8'h3A, 8'h00);
    // R11 receiver disabled
    wr(2'd2, 8'h01);
    drive_frame(8'h5A, 1, 0, 0, 0, 0, 0);
    rd(2'd1, v); chk("R11 disabled no ready", v & 8'h02, 0);
    wr(2'd2, 8'h05);
    // R7 overrun
    drive_frame(8'h11, 1, 0, 0, 0, 0, 0);
    drive_frame(8'h22, 1, 0, 0, 0, 0, 0);
    rd(2'd1, v); chk("R7 overrun status", v, 8'h17);
    rd(2'd0, v); chk("R7 first kept", v, 8'h11);
    rd(2'd1, v); chk("R8 overrun sticky after read", v, 8'h15);
    wr(2'd2, 8'h15);
    rd(2'd1, v); chk("R8 overrun cleared", v, 8'h05);
    // R8 parity error
    wr(2'd1, 8'h34);
    drive_frame(8'h96, 1, 1, 1, 0, 1, 0);
    rd(2'd1, v); chk("R8 parity error", v, 8'h0F);
    rd(2'd0, v); chk("R8 parity data delivered", v, 8'h96);
    rd(2'd1, v); chk("R8 parity sticky", v, 8'h0D);
    wr(2'd2, 8'h05);
    rd(2'd1, v); chk("R8 not cleared without bit4", v, 8'h0D);
    wr(2'd2, 8'h15);
    rd(2'd1, v); chk("R8 parity cleared", v, 8'h05);
    // R8 framing error
    wr(2'd1, 8'h04);
    drive_frame(8'hC3, 1, 0, 0, 0, 0, 1);
    rd(2'd1, v); chk("R8 framing error", v, 8'h27);
    rd(2'd0, v); chk("R8 framing data delivered", v, 8'hC3);
    wr(2'd2, 8'h15);
    rd(2'd1, v); chk("R8 framing cleared", v, 8'h05);
    // R3 next character after framing error
    drive_frame(8'h7E, 1, 0, 0, 0, 0, 0);
    rd(2'd0, v); chk("R3 recovers after framing", v, 8'h7E);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule